// File: doc/BRIEF.md
# 10b/8b Symbol Decoder with Disparity and Code Checking

This block takes one 10-bit line symbol per strobe from an upstream deserializer that is already word aligned. It returns the 8-bit character the symbol carries and a data/control flag. A control symbol is recognised by an exact match of all ten bits against a fixed set of eight control characters, each in both disparity forms. Any other symbol is split into its 6-bit and 4-bit groups. Each group is looked up separately, and the two results are joined into the output byte.

Alongside the decode, the block keeps the running disparity of the lane and raises flags. A code error means the symbol cannot be a legal data character. A disparity error means the symbol's imbalance pushes in the same direction as the current running disparity. A comma flag marks the start of an alignment comma. The running disparity starts at a value chosen on an input pin during reset. All results appear one clock after the strobe.

Top module: `sym_decoder_10b8b`

## Requirements
- R1: Input bit sym[0] is line bit a, the first bit received. Bits sym[1] to sym[5] are b, c, d, e, i, and bits sym[6] to sym[9] are f, g, h, j. Every strobed symbol produces exactly one dec_vld pulse on the following clock, and dec_vld is low in every other cycle.
- R2: Eight control characters are decoded from both disparity forms, with dec_is_data low and the byte value on dec_byte. The pairs are given as a-to-i then f-to-j, negative form first and positive form second. 0x1C: 001111 0100 / 110000 1011. 0x5C: 001111 0101 / 110000 1010. 0x7C: 001111 0011 / 110000 1100. 0xBC: 001111 1010 / 110000 0101. 0xF7: 111010 1000 / 000101 0111. 0xFB: 110110 1000 / 001001 0111. 0xFD: 101110 1000 / 010001 0111. 0xFE: 011110 1000 / 100001 0111.
- R3: Every legal data symbol of both disparities decodes with dec_is_data high and no error flag. Bits 4:0 of dec_byte come from the 6-bit group and bits 7:5 from the 4-bit group.
- R4: A symbol that is not a control character raises dec_code_err in any of three cases: its 6-bit group is not a data code, its 4-bit group is not a data code, or its total count of ones is outside 4 to 6. In that case dec_byte is 0x00 and dec_is_data is high.
- R5: dec_disp_err is raised when a symbol has more than five ones while the running disparity is positive (1), or fewer than five ones while it is negative (0).
- R6: After each strobed symbol, dec_rd becomes 1 if the symbol had more than five ones and 0 if it had fewer than five. A symbol with exactly five ones leaves dec_rd unchanged, and this holds for every symbol, legal or not.
- R7: While rst_n is low, dec_rd takes the value of rd_init.
- R8: dec_comma is raised for a symbol whose bits a and b are equal and whose bits c, d, e, i and f all hold the opposite value.
- R9: In a cycle that follows one without a strobe, dec_vld and all three flags are low, and dec_rd and dec_byte keep their values whatever is on sym.
- R10: In reset, dec_vld, dec_byte, dec_is_data and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_init | input | 1 | Running disparity loaded during reset (1 = positive) |
| sym_vld | input | 1 | Strobe: sym holds a symbol this cycle |
| sym | input | 10 | Received symbol, bit 0 = line bit a |
| dec_vld | output | 1 | Decoded result valid |
| dec_byte | output | 8 | Decoded character |
| dec_is_data | output | 1 | High for a data character, low for a control character |
| dec_comma | output | 1 | Comma pattern seen in the symbol |
| dec_code_err | output | 1 | Symbol is not a legal code |
| dec_disp_err | output | 1 | Symbol imbalance agrees with the current running disparity |
| dec_rd | output | 1 | Current running disparity (1 = positive) |

## Verification
The bench first streams every data byte and then every control character back to back. It does this from each starting disparity, using its own encoder. This shows that the data tables, the control match and the disparity tracking agree with a legal stream, and that such a stream raises no flag. It then sweeps all 1024 ten-bit values after a reset to each disparity. A reference built by inverting that same encoder decides control match, group legality, imbalance and comma. This separates code errors from disparity errors, and legal groups in an illegal pairing from legal symbols. Idle cycles with changing symbol bits show that nothing moves without a strobe.

// File: rtl/sym_decoder_10b8b.sv
module sym_decoder_10b8b (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_init,
  input  logic       sym_vld,
  input  logic [9:0] sym,
  output logic       dec_vld,
  output logic [7:0] dec_byte,
  output logic       dec_is_data,
  output logic       dec_comma,
  output logic       dec_code_err,
  output logic       dec_disp_err,
  output logic       dec_rd
);

  logic [5:0] g6;
  logic [3:0] g4;
  logic [3:0] ones;
  logic [4:0] lo5;
  logic [2:0] hi3;
  logic [7:0] kbyte;
  logic       ok6, ok4, kok, heavy, light, comma, cerr, derr;

  // group bits written left to right in line order (a first, f first)
  assign g6    = {sym[0], sym[1], sym[2], sym[3], sym[4], sym[5]};
  assign g4    = {sym[6], sym[7], sym[8], sym[9]};
  assign ones  = 4'($countones(sym));
  assign heavy = ones > 4'd5;
  assign light = ones < 4'd5;
  assign comma = (sym[1:0] == 2'b00 && sym[6:2] == 5'b11111) ||
                 (sym[1:0] == 2'b11 && sym[6:2] == 5'b00000);
  assign cerr  = !kok && (!ok6 || !ok4 || ones < 4'd4 || ones > 4'd6);
  assign derr  = (dec_rd && heavy) || (!dec_rd && light);

  always_comb begin
    ok6 = 1'b1;
    case (g6)
      6'b100111, 6'b011000: lo5 = 5'd0;
      6'b011101, 6'b100010: lo5 = 5'd1;
      6'b101101, 6'b010010: lo5 = 5'd2;
      6'b110001:            lo5 = 5'd3;
      6'b110101, 6'b001010: lo5 = 5'd4;
      6'b101001:            lo5 = 5'd5;
      6'b011001:            lo5 = 5'd6;
      6'b111000, 6'b000111: lo5 = 5'd7;
      6'b111001, 6'b000110: lo5 = 5'd8;
      6'b100101:            lo5 = 5'd9;
      6'b010101:            lo5 = 5'd10;
      6'b110100:            lo5 = 5'd11;
      6'b001101:            lo5 = 5'd12;
      6'b101100:            lo5 = 5'd13;
      6'b011100:            lo5 = 5'd14;
      6'b010111, 6'b101000: lo5 = 5'd15;
      6'b011011, 6'b100100: lo5 = 5'd16;
      6'b100011:            lo5 = 5'd17;
      6'b010011:            lo5 = 5'd18;
      6'b110010:            lo5 = 5'd19;
      6'b001011:            lo5 = 5'd20;
      6'b101010:            lo5 = 5'd21;
      6'b011010:            lo5 = 5'd22;
      6'b111010, 6'b000101: lo5 = 5'd23;
      6'b110011, 6'b001100: lo5 = 5'd24;
      6'b100110:            lo5 = 5'd25;
      6'b010110:            lo5 = 5'd26;
      6'b110110, 6'b001001: lo5 = 5'd27;
      6'b001110:            lo5 = 5'd28;
      6'b101110, 6'b010001: lo5 = 5'd29;
      6'b011110, 6'b100001: lo5 = 5'd30;
      6'b101011, 6'b010100: lo5 = 5'd31;
      default: begin lo5 = 5'd0; ok6 = 1'b0; end
    endcase
  end

  always_comb begin
    ok4 = 1'b1;
    case (g4)
      4'b1011, 4'b0100:                   hi3 = 3'd0;
      4'b1001:                            hi3 = 3'd1;
      4'b0101:                            hi3 = 3'd2;
      4'b1100, 4'b0011:                   hi3 = 3'd3;
      4'b1101, 4'b0010:                   hi3 = 3'd4;
      4'b1010:                            hi3 = 3'd5;
      4'b0110:                            hi3 = 3'd6;
      4'b1110, 4'b0001, 4'b0111, 4'b1000: hi3 = 3'd7;
      default: begin hi3 = 3'd0; ok4 = 1'b0; end
    endcase
  end

  always_comb begin
    kok = 1'b1;
    case ({g6, g4})
      10'b001111_0100, 10'b110000_1011: kbyte = 8'h1C;
      10'b001111_0101, 10'b110000_1010: kbyte = 8'h5C;
      10'b001111_0011, 10'b110000_1100: kbyte = 8'h7C;
      10'b001111_1010, 10'b110000_0101: kbyte = 8'hBC;
      10'b111010_1000, 10'b000101_0111: kbyte = 8'hF7;
      10'b110110_1000, 10'b001001_0111: kbyte = 8'hFB;
      10'b101110_1000, 10'b010001_0111: kbyte = 8'hFD;
      10'b011110_1000, 10'b100001_0111: kbyte = 8'hFE;
      default: begin kbyte = 8'h00; kok = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_vld      <= 1'b0;
      dec_byte     <= 8'h00;
      dec_is_data  <= 1'b0;
      dec_comma    <= 1'b0;
      dec_code_err <= 1'b0;
      dec_disp_err <= 1'b0;
      dec_rd       <= rd_init;
    end else begin
      dec_vld      <= sym_vld;
      dec_comma    <= sym_vld && comma;
      dec_code_err <= sym_vld && cerr;
      dec_disp_err <= sym_vld && derr;
      if (sym_vld) begin
        dec_is_data <= !kok;
        dec_byte    <= kok ? kbyte : (cerr ? 8'h00 : {hi3, lo5});
        if (heavy)      dec_rd <= 1'b1;
        else if (light) dec_rd <= 1'b0;
      end
    end
  end

  // R1
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_vld |=> dec_vld);

  // R4
  code_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_code_err |-> (dec_is_data && dec_byte == 8'h00));

  // R2
  ctrl_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && !dec_is_data) |-> !dec_code_err);

  // R9
  flag_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_comma || dec_code_err || dec_disp_err) |-> dec_vld);

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_vld |=> ($stable(dec_rd) && $stable(dec_byte)));

endmodule

// File: tb/sym_decoder_10b8b_bench.sv
module sym_decoder_10b8b_bench;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_init = 1'b0;
  logic       sym_vld = 1'b0;
  logic [9:0] sym = '0;
  logic       dec_vld, dec_is_data, dec_comma, dec_code_err, dec_disp_err, dec_rd;
  logic [7:0] dec_byte;

  int  total = 0;
  int  bad = 0;
  logic exp_rd;
  logic [7:0] last_byte;

  always #(PERIOD/2) clk = ~clk;

  sym_decoder_10b8b u_sym_decoder_10b8b (
    .clk(clk), .rst_n(rst_n), .rd_init(rd_init), .sym_vld(sym_vld), .sym(sym),
    .dec_vld(dec_vld), .dec_byte(dec_byte), .dec_is_data(dec_is_data),
    .dec_comma(dec_comma), .dec_code_err(dec_code_err),
    .dec_disp_err(dec_disp_err), .dec_rd(dec_rd)
  );

  function automatic logic [5:0] m6(input int x);
    case (x)
      0: return 6'b100111;  1: return 6'b011101;  2: return 6'b101101;  3: return 6'b110001;
      4: return 6'b110101;  5: return 6'b101001;  6: return 6'b011001;  7: return 6'b111000;
      8: return 6'b111001;  9: return 6'b100101; 10: return 6'b010101; 11: return 6'b110100;
      12: return 6'b001101; 13: return 6'b101100; 14: return 6'b011100; 15: return 6'b010111;
      16: return 6'b011011; 17: return 6'b100011; 18: return 6'b010011; 19: return 6'b110010;
      20: return 6'b001011; 21: return 6'b101010; 22: return 6'b011010; 23: return 6'b111010;
      24: return 6'b110011; 25: return 6'b100110; 26: return 6'b010110; 27: return 6'b110110;
      28: return 6'b001110; 29: return 6'b101110; 30: return 6'b011110; default: return 6'b101011;
    endcase
  endfunction

  function automatic logic [5:0] p6(input int x);
    logic [5:0] m = m6(x);
    return ($countones(m) != 3 || x == 7) ? ~m : m;
  endfunction

  function automatic logic [3:0] m4(input int y);
    case (y)
      0: return 4'b1011; 1: return 4'b1001; 2: return 4'b0101; 3: return 4'b1100;
      4: return 4'b1101; 5: return 4'b1010; 6: return 4'b0110; default: return 4'b1110;
    endcase
  endfunction

  function automatic logic [3:0] p4(input int y);
    logic [3:0] m = m4(y);
    return ($countones(m) != 2 || y == 3) ? ~m : m;
  endfunction

  function automatic logic [7:0] kcode(input int i);
    case (i)
      0: return 8'h1C; 1: return 8'h5C; 2: return 8'h7C; 3: return 8'hBC;
      4: return 8'hF7; 5: return 8'hFB; 6: return 8'hFD; default: return 8'hFE;
    endcase
  endfunction

  function automatic logic [9:0] enc(input logic [7:0] b, input logic k, input logic r);
    int x = int'(b[4:0]);
    int y = int'(b[7:5]);
    logic [5:0] s6;
    logic [3:0] s4;
    logic r1;
    if (k && x == 28) s6 = r ? 6'b110000 : 6'b001111;
    else              s6 = r ? p6(x) : m6(x);
    r1 = ($countones(s6) > 3) ? 1'b1 : ($countones(s6) < 3) ? 1'b0 : r;
    if (y == 7 && (k || (!r1 && (x == 17 || x == 18 || x == 20)) ||
                   (r1 && (x == 11 || x == 13 || x == 14))))
      s4 = r1 ? 4'b1000 : 4'b0111;
    else
      s4 = r1 ? p4(y) : m4(y);
    if (k && x == 28 && !r1 && (y == 1 || y == 2 || y == 5 || y == 6)) s4 = ~s4;
    return {s4[0], s4[1], s4[2], s4[3], s6[0], s6[1], s6[2], s6[3], s6[4], s6[5]};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic init);
    @(negedge clk);
    rst_n = 1'b0; rd_init = init; sym_vld = 1'b0; sym = '0;
    repeat (3) @(negedge clk);
    chk("R7", "rd in reset", 32'(dec_rd), 32'(init));
    rst_n = 1'b1; rd_init = ~init;
    exp_rd = init;
    @(negedge clk);
    chk("R10", "vld", 32'(dec_vld), 0);
    chk("R10", "byte", 32'(dec_byte), 0);
    chk("R10", "is_data", 32'(dec_is_data), 0);
    chk("R10", "flags", 32'({dec_comma, dec_code_err, dec_disp_err}), 0);
    chk("R7", "rd after reset", 32'(dec_rd), 32'(init));
    last_byte = 8'h00;
  endtask

  // drives at a falling edge, checks at the next one
  task automatic xfer(input logic [9:0] s, input logic is_d, input logic [7:0] b, input logic ce, input string req);
    int  n = $countones(s);
    logic de = (exp_rd && n > 5) || (!exp_rd && n < 5);
    logic cm = (s[1:0] == 2'b00 && s[6:2] == 5'b11111) || (s[1:0] == 2'b11 && s[6:2] == 5'b00000);
    sym_vld = 1'b1; sym = s;
    if (n > 5) exp_rd = 1'b1;
    else if (n < 5) exp_rd = 1'b0;
    @(negedge clk);
    chk("R1", "vld", 32'(dec_vld), 1);
    chk(req, "byte", 32'(dec_byte), 32'(b));
    chk(req, "is_data", 32'(dec_is_data), 32'(is_d));
    chk("R4", "code_err", 32'(dec_code_err), 32'(ce));
    chk("R5", "disp_err", 32'(dec_disp_err), 32'(de));
    chk("R8", "comma", 32'(dec_comma), 32'(cm));
    chk("R6", "rd", 32'(dec_rd), 32'(exp_rd));
    last_byte = b;
  endtask

  task automatic idle_check(input logic [9:0] s);
    sym_vld = 1'b0; sym = s;
    @(negedge clk);
    chk("R9", "vld idle", 32'(dec_vld), 0);
    chk("R9", "flags idle", 32'({dec_comma, dec_code_err, dec_disp_err}), 0);
    chk("R9", "rd idle", 32'(dec_rd), 32'(exp_rd));
    chk("R9", "byte idle", 32'(dec_byte), 32'(last_byte));
  endtask

  task automatic raw_sweep();
    for (int v = 0; v < 1024; v++) begin
      logic [9:0] s = 10'(v);
      logic [5:0] g6 = {s[0], s[1], s[2], s[3], s[4], s[5]};
      logic [3:0] g4 = {s[6], s[7], s[8], s[9]};
      logic k = 1'b0, v6 = 1'b0, v4 = 1'b0, ce;
      logic [7:0] kb = 8'h00, b;
      int x6 = 0, y4 = 0, n = $countones(s);
      for (int i = 0; i < 8; i++)
        for (int r = 0; r < 2; r++)
          if (enc(kcode(i), 1'b1, r[0]) == s) begin k = 1'b1; kb = kcode(i); end
      for (int x = 0; x < 32; x++)
        if (g6 == m6(x) || g6 == p6(x)) begin v6 = 1'b1; x6 = x; end
      for (int y = 0; y < 8; y++)
        if (g4 == m4(y) || g4 == p4(y) || (y == 7 && (g4 == 4'b0111 || g4 == 4'b1000))) begin
          v4 = 1'b1; y4 = y;
        end
      ce = !k && (!v6 || !v4 || n < 4 || n > 6);
      b  = k ? kb : (ce ? 8'h00 : {3'(y4), 5'(x6)});
      xfer(s, !k, b, ce, k ? "R2" : (ce ? "R4" : "R3"));
    end
  endtask

  initial begin
    for (int init = 0; init < 2; init++) begin
      do_reset(init[0]);
      for (int b = 0; b < 256; b++)
        xfer(enc(8'(b), 1'b0, exp_rd), 1'b1, 8'(b), 1'b0, "R3");
      for (int i = 0; i < 8; i++)
        xfer(enc(kcode(i), 1'b1, exp_rd), 1'b0, kcode(i), 1'b0, "R2");
      idle_check(10'b1111100000);
      idle_check(10'b0000011111);
      idle_check(10'b0000000000);
    end
    for (int init = 0; init < 2; init++) begin
      do_reset(init[0]);
      raw_sweep();
      idle_check(10'b1111111111);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule